// File: doc/BRIEF.md
# 10BASE-T Receive Line Status Monitor

This block sits behind the slicer of a twisted-pair receiver and keeps a 16-bit, read-only status word for the host. Three small trackers feed that word. A link integrity timer counts idle clocks and drops the link flag after a long quiet period. A polarity judge latches the true line polarity on the strobe that brings the link up. When correction is allowed, it flips the bit stream handed downstream. A carrier tracker raises carrier sense on frame activity and releases it a fixed number of clocks after the last rising data edge.

The receive samples arrive one per clock, with a valid/ready handshake. The block passes them on unchanged, or inverted, over a second valid/ready stream with no storage. The downstream ready is routed straight back to the source as `rx_ready`, and `dn_valid` follows `rx_valid` in the same cycle. A stalled consumer therefore stalls the source directly. The line monitors watch every sample that is marked valid, whether it is accepted or not. A line keeps running under back-pressure. Activity strobes, the correction disable and the interface select are plain level or pulse inputs.

Top module: `rx_line_status`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `line_status` reads 0x0014. Link, polarity and carrier flags are all clear in that state.
- R2: A one-cycle pulse on `link_pulse` or `frame_act` sets bit 7 (link good) in the cycle after it.
- R3: Bit 7 clears exactly LINK_TO_CLKS clocks after the last activity strobe, where LINK_TO_CLKS = CLK_HZ/1000*FAIL_MS. Every strobe restarts this interval.
- R4: Bits 5..0 always read 010100, with bit 0 as the LSB. Bits 15, 13, 11, 10 and 6 always read 0.
- R5: On the strobe that raises the link, bit 12 takes the raw `rx_bit`: 1 means normal polarity and 0 means reversed. Later strobes leave it unchanged while the link stays up. It clears one clock after the link fails.
- R6: Bit 12 does not depend on `pol_fix_dis`.
- R7: `dn_bit` equals `rx_bit` inverted when all three of these hold: the link is up, bit 12 is 0, and `pol_fix_dis` is 0. Otherwise `dn_bit` equals `rx_bit`.
- R8: `dn_valid` equals `rx_valid` and `rx_ready` equals `dn_ready` in the same cycle, for every combination of the two.
- R9: A `frame_act` pulse sets bit 14 (carrier sense) in the next cycle.
- R10: A rising edge is a valid sample of 1 whose previous valid sample was 0. Bit 14 clears exactly REL_CLKS clocks after the last rising edge or `frame_act` pulse, whichever came later. Falling edges and samples without `rx_valid` do not restart this count. REL_CLKS defaults to 2*CLKS_PER_BIT.
- R11: Bit 8 is `aui_sel` and bit 9 is its complement, each registered one clock late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive sample valid |
| rx_bit | input | 1 | Sliced receive data bit |
| rx_ready | output | 1 | Receive sample accepted (equals dn_ready) |
| dn_valid | output | 1 | Downstream sample valid |
| dn_bit | output | 1 | Polarity-corrected data bit |
| dn_ready | input | 1 | Downstream ready |
| link_pulse | input | 1 | Link pulse detected strobe |
| frame_act | input | 1 | Frame activity strobe |
| pol_fix_dis | input | 1 | Disable polarity correction |
| aui_sel | input | 1 | 1 selects the attachment unit port, 0 twisted pair |
| line_status | output | 16 | Status word |

## Verification
Each internal counter is visible at the ports on the clock where it expires. If the idle timer is off by one, bit 7 falls a cycle early or late in the idle sweep. If the release counter misses a restart, bit 14 drops in the middle of a frame within REL_CLKS clocks. A polarity latch that is re-judged while the link is up shows at once as a bit 12 change on the next strobe, and `dn_bit` flips on the same cycle. Errors in the stream path show at once, in the same cycle, because it is purely combinational.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam logic [5:0] STAT_ID  = 6'b010100;
  localparam int         LINK_POS = 7;
  localparam int         AUI_POS  = 8;
  localparam int         TP_POS   = 9;
  localparam int         POL_POS  = 12;
  localparam int         CRS_POS  = 14;
endpackage

// File: rtl/rls_link_mon.sv
module rls_link_mon #(
  parameter int TO_CLKS = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic link_ok
);
  localparam int CW = $clog2(TO_CLKS + 1);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_ok  <= 1'b0;
      idle_cnt <= '0;
    end else if (act) begin
      link_ok  <= 1'b1;
      idle_cnt <= '0;
    end else if (link_ok) begin
      if (idle_cnt == CW'(TO_CLKS - 1)) begin
        link_ok  <= 1'b0;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assert_act_links_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> link_ok);
  // R3: the link only drops when the previous cycle carried no activity
  assert_quiet_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> !$past(act));
endmodule

// File: rtl/rls_pol_track.sv
module rls_pol_track (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic link_ok,
  input  logic raw_bit,
  output logic pol_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) pol_ok <= 1'b0;
    else if (!link_ok) pol_ok <= act ? raw_bit : 1'b0;
  end

  assert_hold_while_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok |=> $stable(pol_ok));
  assert_clear_when_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ok && !act) |=> !pol_ok);
endmodule

// File: rtl/rls_crs_track.sv
module rls_crs_track #(
  parameter int REL_CLKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_act,
  input  logic smp_valid,
  input  logic smp_bit,
  output logic crs
);
  localparam int CW = $clog2(REL_CLKS + 1);
  logic [CW-1:0] rel_cnt;
  logic          prev_bit;
  logic          rise;

  assign rise = smp_valid && smp_bit && !prev_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_bit <= 1'b0;
      rel_cnt  <= '0;
      crs      <= 1'b0;
    end else begin
      if (smp_valid) prev_bit <= smp_bit;
      if (frame_act || rise) rel_cnt <= '0;
      else if (crs && rel_cnt != CW'(REL_CLKS - 1)) rel_cnt <= rel_cnt + 1'b1;
      if (frame_act) crs <= 1'b1;
      else if (crs && !rise && rel_cnt == CW'(REL_CLKS - 1)) crs <= 1'b0;
    end
  end

  assert_frame_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_act |=> crs);
  assert_edge_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (crs && rise) |=> crs);
  assert_fall_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs) |-> !$past(rise || frame_act));
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rls_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int FAIL_MS      = 50,
  parameter int CLKS_PER_BIT = 10,
  parameter int REL_CLKS     = 2 * CLKS_PER_BIT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_bit,
  output logic        rx_ready,
  output logic        dn_valid,
  output logic        dn_bit,
  input  logic        dn_ready,
  input  logic        link_pulse,
  input  logic        frame_act,
  input  logic        pol_fix_dis,
  input  logic        aui_sel,
  output logic [15:0] line_status
);
  localparam int LINK_TO_CLKS = CLK_HZ / 1000 * FAIL_MS;

  logic act, link_ok, pol_ok, crs, aui_q, tp_q, flip;

  assign act = link_pulse | frame_act;

  rls_link_mon #(.TO_CLKS(LINK_TO_CLKS)) u_link (
    .clk(clk), .rst_n(rst_n), .act(act), .link_ok(link_ok)
  );

  rls_pol_track u_pol (
    .clk(clk), .rst_n(rst_n), .act(act), .link_ok(link_ok),
    .raw_bit(rx_bit), .pol_ok(pol_ok)
  );

  rls_crs_track #(.REL_CLKS(REL_CLKS)) u_crs (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act),
    .smp_valid(rx_valid), .smp_bit(rx_bit), .crs(crs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aui_q <= 1'b0;
      tp_q  <= 1'b0;
    end else begin
      aui_q <= aui_sel;
      tp_q  <= !aui_sel;
    end
  end

  assign flip     = link_ok && !pol_ok && !pol_fix_dis;
  assign dn_valid = rx_valid;
  assign rx_ready = dn_ready;
  assign dn_bit   = rx_bit ^ flip;

  always_comb begin
    line_status           = '0;
    line_status[5:0]      = STAT_ID;
    line_status[LINK_POS] = link_ok;
    line_status[AUI_POS]  = aui_q;
    line_status[TP_POS]   = tp_q;
    line_status[POL_POS]  = pol_ok;
    line_status[CRS_POS]  = crs;
  end

  assert_port_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({aui_q, tp_q}) <= 1);
endmodule

// File: tb/rx_line_status_tb.sv
module rx_line_status_tb;
  localparam int TO  = 20;
  localparam int REL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_bit = 0, dn_ready = 0, link_pulse = 0, frame_act = 0;
  logic pol_fix_dis = 0, aui_sel = 0;
  logic rx_ready, dn_valid, dn_bit;
  logic [15:0] line_status;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  rx_line_status #(.CLK_HZ(1000), .FAIL_MS(20), .CLKS_PER_BIT(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_ready(rx_ready), .dn_valid(dn_valid), .dn_bit(dn_bit),
    .dn_ready(dn_ready), .link_pulse(link_pulse), .frame_act(frame_act),
    .pol_fix_dis(pol_fix_dis), .aui_sel(aui_sel), .line_status(line_status)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic lp, input logic fa);
    link_pulse = lp; frame_act = fa;
    step();
    link_pulse = 0; frame_act = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1 reset word", line_status, 16'h0014);
    rst_n = 1;
    chk("R1 first cycle", line_status, 16'h0014);
    step();
    chk("R11 twisted pair bit, R4 id", line_status, 16'h0214);
    aui_sel = 1; step();
    chk("R11 aui bit", line_status, 16'h0114);
    aui_sel = 0; step();
    chk("R11 back to tp", line_status, 16'h0214);

    // R8/R7 stream sweep with link down: no inversion
    for (int i = 0; i < 16; i++) begin
      rx_valid = i[0]; rx_bit = i[1]; dn_ready = i[2]; pol_fix_dis = i[3];
      #1;
      chk("R8 valid", dn_valid, i[0]);
      chk("R8 ready", rx_ready, i[2]);
      chk("R7 link down pass", dn_bit, i[1]);
      @(negedge clk);
    end
    rx_valid = 0; pol_fix_dis = 0;

    // R2/R5 link up with reversed line
    rx_bit = 0; strobe(1, 0);
    chk("R2 link up", line_status[7], 1);
    chk("R5 reversed judged", line_status[12], 0);
    for (int i = 0; i < 4; i++) begin
      rx_bit = i[0]; pol_fix_dis = i[1];
      #1;
      chk("R7 correction", dn_bit, i[0] ^ !i[1]);
      chk("R6 pol independent of disable", line_status[12], 0);
      @(negedge clk);
    end
    pol_fix_dis = 0;
    rx_bit = 1; strobe(1, 0);
    chk("R5 held while up", line_status[12], 0);

    // R3 idle sweep
    rx_bit = 0;
    for (int k = 1; k <= TO + 2; k++) begin
      step();
      chk("R3 timeout sweep", line_status[7], (k < TO) ? 1 : 0);
    end
    chk("R5 cleared after fail", line_status[12], 0);

    // R5 normal polarity on frame activity
    rx_bit = 1; strobe(0, 1);
    chk("R2 frame activity links", line_status[7], 1);
    chk("R5 normal judged", line_status[12], 1);
    pol_fix_dis = 1; #1;
    chk("R6 pol with disable", line_status[12], 1);
    chk("R7 no flip when normal", dn_bit, 1);
    @(negedge clk); pol_fix_dis = 0; rx_bit = 0; #1;
    chk("R7 no flip when normal", dn_bit, 0);
    @(negedge clk);

    // R3 restart: strobes every TO-1 clocks keep the link
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < TO - 2; k++) step();
      strobe(1, 0);
      chk("R3 restart keeps link", line_status[7], 1);
    end
    for (int k = 1; k <= TO + 2; k++) begin
      step();
      chk("R3 timeout after restarts", line_status[7], (k < TO) ? 1 : 0);
    end
    chk("R5 cleared again", line_status[12], 0);
    chk("R4 fixed bits", line_status & 16'hAC7F, 16'h0014);

    // R9/R10 carrier sense
    rx_valid = 1; rx_bit = 0;
    strobe(0, 1);
    chk("R9 carrier set", line_status[14], 1);
    for (int k = 0; k < 24; k++) begin
      rx_bit = k[1];
      step();
      chk("R10 held during toggling", line_status[14], 1);
    end
    rx_bit = 0; step();
    rx_bit = 1; step();
    for (int k = 1; k <= REL + 2; k++) begin
      rx_bit = (k == 1);
      step();
      chk("R10 release after last rise", line_status[14], (k < REL) ? 1 : 0);
    end
    // R10 invalid samples do not restart
    rx_bit = 0; strobe(0, 1);
    for (int k = 1; k <= REL + 2; k++) begin
      rx_valid = 0; rx_bit = k[0];
      step();
      chk("R10 release after frame strobe", line_status[14], (k < REL) ? 1 : 0);
    end
    summary();
  end
endmodule